// File: doc/BRIEF.md
# Command-Sequenced Random Number Source with Automatic Reseed

This block is a random-number peripheral. Software drives it through a small register file. A command register starts one of three operations: nothing, generate, or seed. A mode bit picks a 128-bit or a 256-bit result. The sequencer takes 32-bit words from an entropy port through a valid/ready handshake. A generate places the words into eight result registers. A seed takes a fixed number of words and marks the block seeded. The conditioning stage and the physical entropy source sit outside this block.

Status flags show whether the block is seeded, generating or reseeding. Software treats the block as idle when the seeded flag is the only one of the three that is set. An interrupt-status register holds two write-one-to-clear flags, one for "result ready" and one for "seed done". Both flags update whether or not interrupts are enabled. A request counter counts generate requests in 16-byte units. When it reaches a programmed limit, the next generate is preceded by a reseed. A limit of zero turns this off. A fixed identification register reads 0x46BC.

Top module: `rngc_top`

## Requirements
- R1: After reset the status register (0x04) reads 0x8000_0000 (bit 31 reseeding, bit 9 seeded clear). The block seeds itself from the entropy port and then reads 0x0000_0200 (only bit 9). Once set, bit 9 never clears again.
- R2: Register 0xF0 always reads 0x0000_46BC, and writes to it have no effect.
- R3: A write of 0x01 to the command register (0x00) while idle, with mode register (0x08) bit 3 = 1, sets status bit 30. It then stores the next 8 accepted entropy words, in order, into result registers 0x20, 0x24, … 0x3C, and clears bit 30.
- R4: With mode bit 3 = 0, a generate stores 4 accepted words into 0x20..0x2C and leaves 0x30..0x3C unchanged.
- R5: Interrupt-status (0x14) bit 0 sets when a generate completes, whatever the enables are. Writing 1 to it clears it and writing 0 leaves it. Bit 1 behaves the same way for seed completion. A set and a clear in the same cycle leave the bit set.
- R6: The `irq` output equals, one cycle later, IE bit 31 AND ((ISTAT bit 0 AND IE bit 0) OR (ISTAT bit 1 AND IE bit 1)). IE is register 0x10.
- R7: An entropy word is taken only in a cycle where `ent_valid` and `ent_ready` are both high. While `ent_valid` is low, the operation in progress holds.
- R8: Command writes while the block is not idle are ignored. A write of 0x00 (no-op) or of any code other than 0x01 and 0x02 has no effect.
- R9: A write of 0x02 while idle sets status bit 31 and takes SEED_WORDS (default 4) entropy words. It then sets ISTAT bit 1 and clears the request counter.
- R10: Each completed generate adds 1 (128-bit) or 2 (256-bit) to the request counter. If register 0x60 is nonzero and the counter is at or above it when a generate is issued, a reseed (status bit 31, SEED_WORDS words) runs first and the generate follows. A value of 0 never forces a reseed.
- R11: The mode register reads back only bit 3, IE reads back only bits 31, 1 and 0, and 0x60 reads back its low CNT_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe; data appears on `bus_rdata` the next cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ent_valid | input | 1 | Entropy word available |
| ent_word | input | 32 | Entropy word |
| ent_ready | output | 1 | Sequencer is collecting words (seeding or generating) |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume one register access per cycle. They also assume that `bus_addr` stays stable while a read strobe is high, and that the entropy port may hold `ent_valid` low for any number of cycles. The bench drives every bus access from tasks that raise either the write strobe or the read strobe, never both, for a single cycle. It varies the entropy valid rate from zero to full, including long stalls, so the hold and busy-command properties see both stalled and streaming cycles.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_CTRL  = 8'h00;
  localparam logic [AW-1:0] A_STAT  = 8'h04;
  localparam logic [AW-1:0] A_MODE  = 8'h08;
  localparam logic [AW-1:0] A_IE    = 8'h10;
  localparam logic [AW-1:0] A_ISTAT = 8'h14;
  localparam logic [AW-1:0] A_RES   = 8'h20;
  localparam logic [AW-1:0] A_AUTO  = 8'h60;
  localparam logic [AW-1:0] A_VER   = 8'hF0;

  localparam int STAT_SEEDED = 9;
  localparam int STAT_GEN    = 30;
  localparam int STAT_RESD   = 31;
  localparam int MODE_WIDE   = 3;
  localparam int IE_GIE      = 31;
  localparam int IE_SD       = 1;
  localparam int IE_RDY      = 0;
  localparam int IS_RDY      = 0;
  localparam int IS_SD       = 1;

  typedef enum logic [7:0] {
    CMD_NOP  = 8'h00,
    CMD_GEN  = 8'h01,
    CMD_SEED = 8'h02
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEED,
    ST_GEN
  } seq_st_e;
endpackage

// File: rtl/rngc_seq.sv
module rngc_seq
  import rngc_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int SEED_WORDS = 4,
  localparam int IW = $clog2(NWORDS),
  localparam int MAXW = (NWORDS > SEED_WORDS) ? NWORDS : SEED_WORDS,
  localparam int CW = $clog2(MAXW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd,
  input  logic          wide_sel,
  input  logic          resd_due,
  input  logic          ent_valid,
  output logic          ent_ready,
  output logic          st_seeded,
  output logic          st_gen,
  output logic          st_resd,
  output logic          word_we,
  output logic [IW-1:0] word_idx,
  output logic          seed_fin,
  output logic          gen_fin,
  output logic          gen_wide
);
  localparam logic [CW-1:0] SEED_LAST = CW'(SEED_WORDS - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(NWORDS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(NWORDS / 2 - 1);

  seq_st_e       st;
  logic [CW-1:0] idx;
  logic          gen_pend;
  logic          wide_q;
  logic          seeded_q;
  logic [CW-1:0] gen_last;

  assign gen_last  = wide_q ? FULL_LAST : HALF_LAST;
  assign seed_fin  = (st == ST_SEED) && ent_valid && (idx == SEED_LAST);
  assign gen_fin   = (st == ST_GEN) && ent_valid && (idx == gen_last);
  assign word_we   = (st == ST_GEN) && ent_valid;
  assign word_idx  = idx[IW-1:0];
  assign ent_ready = (st != ST_IDLE);
  assign st_gen    = (st == ST_GEN);
  assign st_resd   = (st == ST_SEED);
  assign st_seeded = seeded_q;
  assign gen_wide  = wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_SEED;
      idx      <= '0;
      gen_pend <= 1'b0;
      wide_q   <= 1'b1;
      seeded_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_wr) begin
            idx <= '0;
            if (cmd == CMD_GEN) begin
              wide_q <= wide_sel;
              if (resd_due) begin
                st       <= ST_SEED;
                gen_pend <= 1'b1;
              end else begin
                st <= ST_GEN;
              end
            end else if (cmd == CMD_SEED) begin
              st       <= ST_SEED;
              gen_pend <= 1'b0;
            end
          end
        end
        ST_SEED: begin
          if (ent_valid) begin
            if (seed_fin) begin
              idx      <= '0;
              seeded_q <= 1'b1;
              st       <= gen_pend ? ST_GEN : ST_IDLE;
              gen_pend <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_GEN: begin
          if (ent_valid) begin
            if (gen_fin) begin
              idx <= '0;
              st  <= ST_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rngc_reseed_ctr.sv
module rngc_reseed_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic             add_two,
  input  logic [CNT_W-1:0] limit,
  output logic             due,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] step;
  assign step = add_two ? CNT_W'(2) : CNT_W'(1);
  assign due  = (limit != '0) && (count >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (add) begin
      count <= (count > MAXV - step) ? MAXV : count + step;
    end
  end
endmodule

// File: rtl/rngc_result.sv
module rngc_result #(
  parameter int NWORDS = 8,
  parameter int WW = 32,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [WW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/rngc_top.sv
module rngc_top
  import rngc_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int SEED_WORDS = 4,
  parameter int CNT_W = 16,
  parameter logic [31:0] VERSION = 32'h0000_46BC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wen,
  input  logic          bus_ren,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ent_valid,
  input  logic [31:0]   ent_word,
  output logic          ent_ready,
  output logic          irq
);
  localparam int IW = $clog2(NWORDS);

  logic             wr_ctrl, wr_mode, wr_ie, wr_istat, wr_auto;
  logic [31:0]      ctrl_q;
  logic             wide_q, gie_q, sde_q, rde_q;
  logic             is_rdy, is_sd;
  logic [CNT_W-1:0] lim_q, req_cnt;
  logic             irq_q;
  logic             st_seeded, st_gen, st_resd;
  logic             word_we, seed_fin, gen_fin, gen_wide, resd_due;
  logic [IW-1:0]    word_idx, ridx;
  logic [AW-1:0]    res_off;
  logic             in_res, rd_sel_q;
  logic [31:0]      reg_mux, rd_q, res_q;

  assign wr_ctrl  = bus_wen && (bus_addr == A_CTRL);
  assign wr_mode  = bus_wen && (bus_addr == A_MODE);
  assign wr_ie    = bus_wen && (bus_addr == A_IE);
  assign wr_istat = bus_wen && (bus_addr == A_ISTAT);
  assign wr_auto  = bus_wen && (bus_addr == A_AUTO);

  rngc_seq #(.NWORDS(NWORDS), .SEED_WORDS(SEED_WORDS)) u_seq (
    .clk(clk), .rst(rst), .cmd_wr(wr_ctrl), .cmd(bus_wdata[7:0]),
    .wide_sel(wide_q), .resd_due(resd_due), .ent_valid(ent_valid),
    .ent_ready(ent_ready), .st_seeded(st_seeded), .st_gen(st_gen),
    .st_resd(st_resd), .word_we(word_we), .word_idx(word_idx),
    .seed_fin(seed_fin), .gen_fin(gen_fin), .gen_wide(gen_wide)
  );

  rngc_reseed_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(seed_fin), .add(gen_fin),
    .add_two(gen_wide), .limit(lim_q), .due(resd_due), .count(req_cnt)
  );

  assign res_off = bus_addr - A_RES;
  assign in_res  = (res_off[1:0] == 2'b00) && (res_off[AW-1:2] < (AW-2)'(NWORDS));
  assign ridx    = res_off[IW+1:2];

  rngc_result #(.NWORDS(NWORDS), .WW(32)) u_res (
    .clk(clk), .we(word_we), .widx(word_idx), .wdata(ent_word),
    .re(bus_ren), .ridx(ridx), .rdata(res_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      wide_q <= 1'b0;
      gie_q  <= 1'b0;
      sde_q  <= 1'b0;
      rde_q  <= 1'b0;
      is_rdy <= 1'b0;
      is_sd  <= 1'b0;
      lim_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_mode) wide_q <= bus_wdata[MODE_WIDE];
      if (wr_ie) begin
        gie_q <= bus_wdata[IE_GIE];
        sde_q <= bus_wdata[IE_SD];
        rde_q <= bus_wdata[IE_RDY];
      end
      if (wr_auto) lim_q <= bus_wdata[CNT_W-1:0];
      is_rdy <= gen_fin  | (is_rdy & ~(wr_istat & bus_wdata[IS_RDY]));
      is_sd  <= seed_fin | (is_sd  & ~(wr_istat & bus_wdata[IS_SD]));
      irq_q  <= gie_q & ((is_rdy & rde_q) | (is_sd & sde_q));
    end
  end

  always_comb begin
    reg_mux = '0;
    case (bus_addr)
      A_CTRL: reg_mux = ctrl_q;
      A_STAT: begin
        reg_mux[STAT_SEEDED] = st_seeded;
        reg_mux[STAT_GEN]    = st_gen;
        reg_mux[STAT_RESD]   = st_resd;
      end
      A_MODE: reg_mux[MODE_WIDE] = wide_q;
      A_IE: begin
        reg_mux[IE_GIE] = gie_q;
        reg_mux[IE_SD]  = sde_q;
        reg_mux[IE_RDY] = rde_q;
      end
      A_ISTAT: begin
        reg_mux[IS_RDY] = is_rdy;
        reg_mux[IS_SD]  = is_sd;
      end
      A_AUTO: reg_mux = 32'(lim_q);
      A_VER:  reg_mux = VERSION;
      default: reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      rd_sel_q <= 1'b0;
    end else if (bus_ren) begin
      rd_q     <= reg_mux;
      rd_sel_q <= in_res;
    end
  end

  assign bus_rdata = rd_sel_q ? res_q : rd_q;
  assign irq       = irq_q;
endmodule

// File: rtl/rngc_chk.sv
module rngc_chk
  import rngc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [31:0] VERSION = 32'h0000_46BC
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wen,
  input logic             bus_ren,
  input logic [7:0]       bus_addr,
  input logic             clr_bit,
  input logic [31:0]      bus_rdata,
  input logic             ent_valid,
  input logic             irq,
  input logic             st_seeded,
  input logic             st_gen,
  input logic             st_resd,
  input logic             is_rdy,
  input logic             gie_q,
  input logic [CNT_W-1:0] req_cnt
);
  a_r1_seeded_sticky: assert property (@(posedge clk) disable iff (rst)
    st_seeded |=> st_seeded);

  a_r2_version: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr == A_VER) |=> (bus_rdata == VERSION));

  a_r3_gen_after_seed: assert property (@(posedge clk) disable iff (rst)
    st_gen |-> st_seeded);

  a_r5_clear_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == A_ISTAT && clr_bit && !st_gen) |=> !is_rdy);

  a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie_q));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (st_gen && !ent_valid) |=> st_gen);

  a_r8_busy_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (st_gen && !ent_valid && bus_wen && bus_addr == A_CTRL) |=> (st_gen && !st_resd));

  a_r9_seed_clears_count: assert property (@(posedge clk) disable iff (rst)
    $fell(st_resd) |-> (req_cnt == '0));
endmodule

bind rngc_top rngc_chk #(.CNT_W(CNT_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
  .bus_addr(bus_addr), .clr_bit(bus_wdata[0]), .bus_rdata(bus_rdata),
  .ent_valid(ent_valid), .irq(irq), .st_seeded(st_seeded),
  .st_gen(st_gen), .st_resd(st_resd), .is_rdy(is_rdy),
  .gie_q(gie_q), .req_cnt(req_cnt)
);

// File: tb/rngc_top_bench.sv
module rngc_top_bench;
  localparam int CLK_NS = 10;
  localparam int NW = 8;
  localparam int SW = 4;

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_MODE = 8'h08,
    A_IE = 8'h10, A_ISTAT = 8'h14, A_RES = 8'h20, A_AUTO = 8'h60, A_VER = 8'hF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_valid = 1'b0;
  logic [31:0] ent_word = '0;
  logic        ent_ready, irq;

  int total = 0, bad = 0;
  bit done = 0;
  bit ent_on = 0;
  int pct = 100;
  int unsigned n_taken = 0;
  int cnt_m = 0, lim_m = 0;
  logic [31:0] res_m [NW];

  rngc_top u_rngc_top (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_word(ent_word), .ent_ready(ent_ready), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] ent_val(input int unsigned n);
    return (32'h9E37_79B9 * (n + 1)) ^ 32'h5A5A_0000;
  endfunction

  always @(negedge clk) begin
    ent_valid = ent_on && (($urandom % 100) < pct);
    ent_word  = ent_val(n_taken);
    if (ent_valid && ent_ready) n_taken++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(A_STAT, s);
      if ((s & 32'hC000_0200) == 32'h0000_0200) return;
    end
    chk(1'b0, "R1 idle timeout", s, 32'h0000_0200);
  endtask

  task automatic do_gen(input bit wide, input bit keep);
    logic [31:0] d;
    bit due;
    int unsigned n0, base, nw;
    wr(A_MODE, wide ? 32'h8 : 32'h0);
    due = (lim_m != 0) && (cnt_m >= lim_m);
    n0 = n_taken;
    wr(A_CTRL, 32'h1);
    if (due) begin
      rd(A_STAT, d);
      chk(d[31] == 1'b1, "R10 auto reseed precedes generate", d, 32'h8000_0200);
    end
    wait_idle();
    nw = wide ? NW : NW / 2;
    chk(n_taken - n0 == (due ? SW : 0) + nw, wide ? "R3/R10 words taken" : "R4/R10 words taken",
        n_taken - n0, (due ? SW : 0) + nw);
    base = n0 + (due ? SW : 0);
    for (int i = 0; i < int'(nw); i++) res_m[i] = ent_val(base + i);
    for (int i = 0; i < NW; i++) begin
      rd(A_RES + 8'(4 * i), d);
      chk(d == res_m[i], wide ? "R3 result word" : "R4 result word", d, res_m[i]);
    end
    cnt_m = (due ? 0 : cnt_m) + (wide ? 2 : 1);
    rd(A_ISTAT, d);
    chk(d[0] == 1'b1, "R5 ready flag set", d, 32'h1);
    if (!keep) wr(A_ISTAT, 32'h3);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned n0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(A_STAT, d);
    chk(d == 32'h8000_0000, "R1 reset status", d, 32'h8000_0000);
    rd(A_VER, d);
    chk(d == 32'h0000_46BC, "R2 version", d, 32'h0000_46BC);
    wr(A_VER, 32'h0);
    rd(A_VER, d);
    chk(d == 32'h0000_46BC, "R2 version after write", d, 32'h0000_46BC);

    ent_on = 1;
    wait_idle();
    rd(A_STAT, d);
    chk(d == 32'h0000_0200, "R1 seeded status", d, 32'h0000_0200);
    chk(n_taken == SW, "R9 initial seed words", n_taken, SW);
    rd(A_ISTAT, d);
    chk(d == 32'h2, "R9 seed done flag", d, 32'h2);
    wr(A_ISTAT, 32'h3);
    rd(A_ISTAT, d);
    chk(d == 32'h0, "R5 flags cleared", d, 32'h0);

    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, d);
    chk(d == 32'h8, "R11 mode readback", d, 32'h8);
    wr(A_IE, 32'hFFFF_FFFF);
    rd(A_IE, d);
    chk(d == 32'h8000_0003, "R11 ie readback", d, 32'h8000_0003);
    wr(A_AUTO, 32'hFFFF_1234);
    rd(A_AUTO, d);
    chk(d == 32'h0000_1234, "R11 auto readback", d, 32'h0000_1234);
    wr(A_AUTO, 32'h0);
    wr(A_IE, 32'h8000_0001);

    do_gen(1'b1, 1'b1);
    chk(irq == 1'b1, "R6 irq with ready", irq, 1);
    wr(A_ISTAT, 32'h0);
    rd(A_ISTAT, d);
    chk(d[0] == 1'b1, "R5 write zero keeps flag", d, 32'h1);
    wr(A_IE, 32'h0000_0001);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R6 irq gated by global enable", irq, 0);
    wr(A_IE, 32'h8000_0001);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R6 irq re-enabled", irq, 1);
    wr(A_ISTAT, 32'h1);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R6 irq after clear", irq, 0);

    pct = 40;
    do_gen(1'b0, 1'b0);
    pct = 100;

    pct = 0;
    n0 = n_taken;
    wr(A_MODE, 32'h8);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 4; i++) begin
      rd(A_STAT, d);
      chk(d == 32'h4000_0200, "R7 generate holds on stall", d, 32'h4000_0200);
    end
    chk(n_taken == n0, "R7 no words without valid", n_taken, n0);
    wr(A_CTRL, 32'h2);
    pct = 100;
    wait_idle();
    chk(n_taken - n0 == NW, "R8 busy command ignored", n_taken - n0, NW);
    for (int i = 0; i < NW; i++) res_m[i] = ent_val(n0 + i);
    rd(A_RES + 8'h1C, d);
    chk(d == res_m[NW-1], "R7 last word after stall", d, res_m[NW-1]);
    cnt_m += 2;
    wr(A_ISTAT, 32'h3);

    n0 = n_taken;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h7);
    repeat (4) @(negedge clk);
    rd(A_STAT, d);
    chk(d == 32'h0000_0200, "R8 nop and unknown code", d, 32'h0000_0200);
    chk(n_taken == n0, "R8 no words on nop", n_taken, n0);

    n0 = n_taken;
    wr(A_CTRL, 32'h2);
    rd(A_STAT, d);
    chk(d[31] == 1'b1, "R9 reseeding shown", d, 32'h8000_0200);
    wait_idle();
    chk(n_taken - n0 == SW, "R9 seed words", n_taken - n0, SW);
    rd(A_ISTAT, d);
    chk(d[1] == 1'b1, "R9 seed done flag", d, 32'h2);
    cnt_m = 0;
    wr(A_ISTAT, 32'h3);

    wr(A_AUTO, 32'd3); lim_m = 3;
    repeat (3) do_gen(1'b1, 1'b0);
    wr(A_AUTO, 32'd2); lim_m = 2;
    repeat (3) do_gen(1'b0, 1'b0);
    wr(A_AUTO, 32'd0); lim_m = 0;
    repeat (3) do_gen(1'b1, 1'b0);

    for (int k = 0; k < 16; k++) begin
      lim_m = int'($urandom % 4);
      wr(A_AUTO, 32'(lim_m));
      pct = 30 + int'($urandom % 71);
      do_gen(1'($urandom % 2), 1'b0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule